// File: doc/BRIEF.md
# Symmetric Bicycle Light Sequencer

This block animates a five-LED bicycle light. Two lit LEDs start together at the centre and move apart, one toward each end, so the pattern is always symmetric about the middle LED. The pattern advances by one frame on each step pulse. An internal programmable tick divider produces these pulses, so each frame stays on the display for a fixed number of clock cycles that software chooses through a period input.

A mode input selects how the pattern continues once the pair reaches the outer LEDs. In restart mode the light jumps back to the centre-only frame. In bounce mode the pair turns around and travels back to the centre. A mode change is taken in only when the pattern leaves the centre frame, so a half-finished sweep is never cut short. The frame is built by OR-ing two one-hot pointers that move in opposite directions.

Top module: `bike_light_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `led_o` to the centre-only frame 5'b00100 (bit 2 is the centre LED) and clears the tick counter, so the first frame also lasts `period_i`+1 cycles after reset is released.
- R2: `led_o` is always the OR of a right-moving and a left-moving one-hot pointer that mirror each other, so only the frames 5'b00100, 5'b01010 and 5'b10001 can appear.
- R3: Each frame is held for exactly P+1 clock cycles, where P is the period value captured when that frame began, and `led_o` changes at no other time.
- R4: Moving outward, the frame order is 5'b00100, then 5'b01010, then 5'b10001.
- R5: In restart mode (mode value 0) the frame after 5'b10001 is 5'b00100, giving the repeating cycle 00100, 01010, 10001.
- R6: In bounce mode (mode value 1) the pair turns at the ends, giving the repeating cycle 00100, 01010, 10001, 01010.
- R7: `mode_i` is sampled only on the step that leaves the centre frame (and during reset); a change at any other time has no effect on the frames until the next departure from the centre.
- R8: `period_i` is sampled only when a new frame begins (and during reset); a change in the middle of a frame does not alter the length of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0 = restart at the centre, 1 = bounce back |
| period_i | input | PERIOD_W | Frame hold length minus one, in clock cycles |
| led_o | output | NUM_LEDS | LED pattern, bit 2 is the centre |

## Verification
Two pairs of events can fall in the same cycle. A mode change can land on the very step that leaves the centre frame, which decides whether the new mode applies to the sweep that is starting. A period change can land on the cycle in which the counter wraps, which decides whether the new value sets the length of the next frame. The bench provokes both with random mode and period changes at random cycles, mixed with directed changes placed in the middle of a sweep and in the middle of a frame. A cycle-level reference model gives the expected frame at every cycle, and each cycle's output is compared against it.

// File: rtl/blseq_pkg.sv
package blseq_pkg;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } scan_dir_e;

    typedef enum logic {
        MODE_RESTART = 1'b0,
        MODE_BOUNCE  = 1'b1
    } scan_mode_e;

endpackage

// File: rtl/blseq_tick.sv
module blseq_tick #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                step_o
);

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic [PERIOD_W-1:0] per;
    } tick_state_t;

    tick_state_t t_q, t_d;
    logic        wrap;

    assign wrap   = (t_q.cnt == t_q.per);
    assign step_o = wrap;

    always_comb begin
        t_d = t_q;
        if (rst) begin
            t_d.cnt = '0;
            t_d.per = period_i;
        end else if (wrap) begin
            t_d.cnt = '0;
            t_d.per = period_i;
        end else begin
            t_d.cnt = t_q.cnt + PERIOD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    // R3: the counter never runs past the captured period
    a_r3_cnt_bound : assert property (@(posedge clk) disable iff (rst)
        t_q.cnt <= t_q.per);

    // R8: the captured period only moves when a frame begins
    a_r8_period_hold : assert property (@(posedge clk) disable iff (rst)
        !step_o |=> $stable(t_q.per));

endmodule

// File: rtl/blseq_scan.sv
module blseq_scan
    import blseq_pkg::*;
#(
    parameter int NUM_LEDS = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_i,
    input  logic                mode_i,
    output logic [NUM_LEDS-1:0] frame_o
);

    localparam int                CTR    = NUM_LEDS / 2;
    localparam logic [NUM_LEDS-1:0] CENTRE = NUM_LEDS'(1) << CTR;

    typedef struct packed {
        logic [NUM_LEDS-1:0] right;
        logic [NUM_LEDS-1:0] left;
        scan_dir_e           dir;
        scan_mode_e          mode;
    } scan_state_t;

    scan_state_t s_q, s_d;
    logic        at_centre;
    logic        at_edge;

    assign at_centre = s_q.right[CTR];
    assign at_edge   = s_q.left[NUM_LEDS-1];

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d.right = CENTRE;
            s_d.left  = CENTRE;
            s_d.dir   = DIR_OUT;
            s_d.mode  = scan_mode_e'(mode_i);
        end else if (step_i) begin
            if (at_centre) begin
                s_d.mode  = scan_mode_e'(mode_i);
                s_d.dir   = DIR_OUT;
                s_d.right = s_q.right >> 1;
                s_d.left  = s_q.left << 1;
            end else if (s_q.dir == DIR_OUT && at_edge) begin
                if (s_q.mode == MODE_RESTART) begin
                    s_d.right = CENTRE;
                    s_d.left  = CENTRE;
                end else begin
                    s_d.dir   = DIR_IN;
                    s_d.right = s_q.right << 1;
                    s_d.left  = s_q.left >> 1;
                end
            end else if (s_q.dir == DIR_OUT) begin
                s_d.right = s_q.right >> 1;
                s_d.left  = s_q.left << 1;
            end else begin
                s_d.right = s_q.right << 1;
                s_d.left  = s_q.left >> 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // one OR gate per LED position
    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
        assign frame_o[g] = s_q.right[g] | s_q.left[g];
    end

    // R2: each pointer stays one-hot
    a_r2_right_onehot : assert property (@(posedge clk) disable iff (rst)
        $countones(s_q.right) == 1);
    a_r2_left_onehot : assert property (@(posedge clk) disable iff (rst)
        $countones(s_q.left) == 1);

    // R2: pointers mirror each other about the centre
    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_mirror
        a_r2_mirror : assert property (@(posedge clk) disable iff (rst)
            s_q.right[g] == s_q.left[NUM_LEDS-1-g]);
    end

    // R5: restart mode returns to the centre after the outer pair
    a_r5_restart_wrap : assert property (@(posedge clk) disable iff (rst)
        (step_i && s_q.mode == MODE_RESTART && s_q.dir == DIR_OUT && at_edge)
        |=> s_q.right[CTR]);

    // R6: bounce mode turns inward after the outer pair
    a_r6_bounce_turn : assert property (@(posedge clk) disable iff (rst)
        (step_i && s_q.mode == MODE_BOUNCE && s_q.dir == DIR_OUT && at_edge)
        |=> (s_q.dir == DIR_IN && !s_q.left[NUM_LEDS-1]));

    // R7: the active mode only moves when leaving the centre frame
    a_r7_mode_hold : assert property (@(posedge clk) disable iff (rst)
        !(step_i && at_centre) |=> $stable(s_q.mode));

endmodule

// File: rtl/bike_light_seq.sv
module bike_light_seq #(
    parameter int NUM_LEDS = 5,
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic [NUM_LEDS-1:0] led_o
);

    localparam int                  CTR    = NUM_LEDS / 2;
    localparam logic [NUM_LEDS-1:0] CENTRE = NUM_LEDS'(1) << CTR;

    logic step_w;

    blseq_tick #(
        .PERIOD_W (PERIOD_W)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .step_o   (step_w)
    );

    blseq_scan #(
        .NUM_LEDS (NUM_LEDS)
    ) u_scan (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step_w),
        .mode_i  (mode_i),
        .frame_o (led_o)
    );

    // R1: first cycle out of reset shows the centre-only frame
    a_r1_reset_frame : assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> led_o == CENTRE);

    // R3: the display only changes on a step
    a_r3_hold_frame : assert property (@(posedge clk) disable iff (rst)
        !step_w |=> $stable(led_o));

    // R4: leaving the centre always lights the inner pair
    a_r4_leave_centre : assert property (@(posedge clk) disable iff (rst)
        (step_w && led_o == CENTRE) |=> (led_o[CTR] == 1'b0 && $countones(led_o) == 2));

endmodule

// File: tb/bike_light_seq_tb.sv
module bike_light_seq_tb;

    localparam int N  = 5;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_i = 1'b0;
    logic [PW-1:0] period_i = 16'd3;
    logic [N-1:0]  led_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    string ph_tag = "";

    // reference model state
    int m_cnt, m_per, m_pos;
    bit m_out, m_mode;
    string m_tag = "R1";

    always #5 clk = ~clk;

    bike_light_seq #(.NUM_LEDS(N), .PERIOD_W(PW)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mode_i),
        .period_i (period_i),
        .led_o    (led_o)
    );

    function automatic logic [N-1:0] exp_frame(int pos);
        logic [N-1:0] f = '0;
        f[N/2 + pos] = 1'b1;
        f[N/2 - pos] = 1'b1;
        return f;
    endfunction

    function automatic bit legal(logic [N-1:0] f);
        return f == 5'b00100 || f == 5'b01010 || f == 5'b10001;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // advance the model by one edge using the inputs held at that edge
    task automatic model_edge();
        if (rst) begin
            m_cnt = 0; m_per = int'(period_i); m_pos = 0;
            m_out = 1'b1; m_mode = mode_i; m_tag = "R1";
        end else if (m_cnt == m_per) begin
            m_cnt = 0; m_per = int'(period_i);
            if (m_pos == 0) begin
                m_mode = mode_i; m_pos = 1; m_out = 1'b1; m_tag = "R4";
            end else if (m_out && m_pos == N/2) begin
                if (!m_mode) begin m_pos = 0; m_tag = "R5"; end
                else begin m_pos = N/2 - 1; m_out = 1'b0; m_tag = "R6"; end
            end else if (m_out) begin
                m_pos++; m_tag = "R4";
            end else begin
                m_pos--; m_tag = "R6";
            end
        end else begin
            m_cnt++; m_tag = "R3";
        end
    endtask

    task automatic tick();
        @(negedge clk);
        model_edge();
        check((ph_tag != "") ? ph_tag : m_tag, led_o, exp_frame(m_pos));
        total++;
        if (!legal(led_o)) begin
            bad++;
            $display("FAIL R2 actual=%b expected=legal frame at %0t", led_o, $time);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state and first frame length
        run(3);
        rst = 1'b0;
        ph_tag = "R1";
        run(4);
        ph_tag = "";
        // R4 R5: restart mode, period 3, five full cycles
        run(60);
        // R7: switch to bounce part way through a sweep
        ph_tag = "R7";
        run(5);
        mode_i = 1'b1;
        run(12);
        ph_tag = "";
        // R6: bounce mode, several full cycles
        run(80);
        // R8: period change in the middle of a frame
        ph_tag = "R8";
        period_i = 16'd6;
        run(2);
        period_i = 16'd1;
        run(30);
        ph_tag = "";
        // R3: period zero steps every cycle in both modes
        period_i = 16'd0;
        run(20);
        mode_i = 1'b0;
        run(20);
        // R7 R8: random mode and period changes at random cycles
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 5) == 0) mode_i = ~mode_i;
            if ($urandom_range(0, 7) == 0) period_i = PW'($urandom_range(0, 5));
            tick();
        end
        // R1: reset in the middle of a pattern
        rst = 1'b1;
        period_i = 16'd2;
        run(2);
        rst = 1'b0;
        ph_tag = "R1";
        run(3);
        ph_tag = "";
        run(30);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R3 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule